// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block sits beside a small processor core and decides, one cycle at a time, whether the core may take a maskable interrupt and which source wins. Each source has a pending flag, a mask bit and a one-bit level. Level 0 is the high level and level 1 is the low level. The arbiter holds a global enable flag and an in-service level flag (`isp`). `isp` = 0 means a high-level handler is running. `isp` = 1 means either no handler is running or a low-level handler is running. The block also keeps a small internal LIFO of saved flag pairs, so that a return from a nested handler restores the state that was in force before it.

The core gives the arbiter strobes for enable, disable, return, software break and instruction completed. Taking an interrupt or a break saves the flags, clears the enable flag and pulses an acknowledge output. The core must then issue an enable strobe before nesting can happen. The arbiter does not clear request flags: a request that is blocked stays visible on `req_i` until it is taken.

Control is a two-state machine. `ST_OPEN` is the normal state, in which a maskable request may be taken. `ST_GUARD` is entered after a return and blocks maskable acknowledges. There are two transitions. `ret_seen` goes from either state to `ST_GUARD` when `reti_i` is high. `insn_retired` goes from `ST_GUARD` to `ST_OPEN` when `insn_done_i` is high without `reti_i`. The first acknowledge decision after a return can therefore come no earlier than the cycle after an instruction completes.

Top module: `nest_irq_arbiter`

## Requirements
- R1: After reset, `ie_o`=0, `isp_o`=1, `stk_err_o`=0, `ack_o`=0 and `brk_ack_o`=0, and the save stack is empty.
- R2: A maskable request is taken only when the state is `ST_OPEN`, the enable flag is 1 and at least one source is eligible. When it is taken, `ack_o` is high for exactly one cycle, in the cycle after the decision, and `ack_src_o` holds the winner's index.
- R3: A source is eligible when its `req_i` bit is 1, its `mask_i` bit is 0 (1 means masked), and either its `lvl_i` bit is 0 or `isp` is 1. With `isp`=0, low-level sources (`lvl_i`=1) are never taken.
- R4: Among eligible sources, the lowest index wins. Masked sources never win.
- R5: Taking a maskable request pushes {enable, isp} onto the stack, clears the enable flag and sets `isp` to the winner's `lvl_i` bit.
- R6: A request that is blocked by a cleared enable flag or by the level rule is not lost. It is taken once the conditions allow, as long as its `req_i` bit is still 1.
- R7: `reti_i` pops the stack and restores both flags, then moves to `ST_GUARD`. No maskable acknowledge is issued until the cycle after an `insn_done_i` pulse that arrives without `reti_i`.
- R8: `brk_i` is taken whatever the enable flag, `isp` and the state are. It pushes the flags, clears the enable flag, leaves `isp` unchanged and pulses `brk_ack_o` for one cycle.
- R9: A push while the stack holds `STACK_DEPTH` entries, or a pop while it is empty, sets `stk_err_o`. That flag stays set until reset. In that case the flags stay unchanged and no acknowledge pulse is issued.
- R10: In a single cycle the precedence is return, then break, then maskable acknowledge, then disable, then enable. `di_i` clears the enable flag and `ei_i` sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Pending request flags |
| mask_i | input | NUM_SRC | Per-source mask, 1 = masked |
| lvl_i | input | NUM_SRC | Per-source level, 0 = high, 1 = low |
| ei_i | input | 1 | Set enable flag strobe |
| di_i | input | 1 | Clear enable flag strobe |
| reti_i | input | 1 | Return-from-handler strobe |
| insn_done_i | input | 1 | Instruction-completed strobe |
| brk_i | input | 1 | Software break strobe |
| ack_o | output | 1 | Maskable acknowledge pulse |
| ack_src_o | output | SRC_W | Index of the acknowledged source |
| brk_ack_o | output | 1 | Break taken pulse |
| ie_o | output | 1 | Global enable flag |
| isp_o | output | 1 | In-service level flag |
| stk_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench builds the arbiter with `NUM_SRC`=6 and `STACK_DEPTH`=3. A non-power-of-two source count exercises the index encoding at an uneven width. A three-deep stack is filled after only three nested acknowledges, so both overflow and underflow are reached in the directed sequence. With so few sources, a random phase of sparse requests, masks and strobes often produces ties at the same level, blocked low-level requests, returns that arrive back to back, and breaks that land on a full stack. Each of these is compared against a behavioural model on every cycle.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

    typedef enum logic {
        ST_OPEN  = 1'b0,
        ST_GUARD = 1'b1
    } arb_state_t;

    typedef struct packed {
        logic ie;
        logic isp;
    } irq_flags_t;

endpackage

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] elig_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Fixed priority: the lowest index wins, because the loop runs downward
    // and the last assignment made is the one that sticks.
    always_comb begin
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign any_o = |elig_i;

    always_comb begin
        if (any_o) begin
            a_pick_valid_r4: assert (elig_i[idx_o])
                else $error("picked source is not eligible");
        end
    end
endmodule

// File: rtl/irq_flag_stack.sv
module irq_flag_stack
    import nest_irq_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic       pop_i,
    input  irq_flags_t push_data_i,
    output irq_flags_t top_o,
    output logic       full_o,
    output logic       empty_o
);
    localparam int AW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
    localparam int CW = $clog2(STACK_DEPTH + 1);

    irq_flags_t      mem_q [STACK_DEPTH];
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   cnt_m1;

    assign cnt_m1  = cnt_q - CW'(1);
    assign full_o  = (cnt_q == CW'(STACK_DEPTH));
    assign empty_o = (cnt_q == '0);
    assign top_o   = empty_o ? '0 : mem_q[cnt_m1[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push_i && !full_o) begin
            mem_q[cnt_q[AW-1:0]] <= push_data_i;
            cnt_q                <= cnt_q + CW'(1);
        end else if (pop_i && !empty_o) begin
            cnt_q <= cnt_m1;
        end
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(STACK_DEPTH))
        else $error("stack count above depth");

    p_pop_lowers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (cnt_q == $past(cnt_m1)))
        else $error("pop did not lower count");
endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
    import nest_irq_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int STACK_DEPTH = 4,
    localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] lvl_i,
    input  logic               ei_i,
    input  logic               di_i,
    input  logic               reti_i,
    input  logic               insn_done_i,
    input  logic               brk_i,
    output logic               ack_o,
    output logic [SRC_W-1:0]   ack_src_o,
    output logic               brk_ack_o,
    output logic               ie_o,
    output logic               isp_o,
    output logic               stk_err_o
);
    arb_state_t state_q, state_d;

    logic             ie_q, ie_d, isp_q, isp_d, err_q, err_d;
    logic             ack_q, ack_d, brk_q, brk_d;
    logic [SRC_W-1:0] src_q, src_d;
    logic [NUM_SRC-1:0] elig;
    logic             any_elig;
    logic [SRC_W-1:0] win_idx;
    logic             push, pop, stk_full, stk_empty, take_ok;
    irq_flags_t       stk_top, cur_flags;

    // A source is eligible when it is pending, not masked, and its level is
    // allowed by the level now in service.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        assign elig[g] = req_i[g] & ~mask_i[g] & (~lvl_i[g] | isp_q);
    end

    irq_src_pick #(.NUM_SRC(NUM_SRC), .IDX_W(SRC_W)) u_pick (
        .elig_i (elig),
        .any_o  (any_elig),
        .idx_o  (win_idx)
    );

    assign cur_flags = '{ie: ie_q, isp: isp_q};

    irq_flag_stack #(.STACK_DEPTH(STACK_DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (cur_flags),
        .top_o       (stk_top),
        .full_o      (stk_full),
        .empty_o     (stk_empty)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // Next state and event selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:  if (reti_i) state_d = ST_GUARD;
            ST_GUARD: if (!reti_i && insn_done_i) state_d = ST_OPEN;
        endcase

        take_ok = (state_q == ST_OPEN) && ie_q && any_elig;
        ie_d  = ie_q;
        isp_d = isp_q;
        err_d = err_q;
        ack_d = 1'b0;
        brk_d = 1'b0;
        src_d = src_q;
        push  = 1'b0;
        pop   = 1'b0;

        if (reti_i) begin
            if (stk_empty) begin
                err_d = 1'b1;
            end else begin
                pop   = 1'b1;
                ie_d  = stk_top.ie;
                isp_d = stk_top.isp;
            end
        end else if (brk_i) begin
            if (stk_full) begin
                err_d = 1'b1;
            end else begin
                push  = 1'b1;
                ie_d  = 1'b0;
                brk_d = 1'b1;
            end
        end else if (take_ok) begin
            if (stk_full) begin
                err_d = 1'b1;
            end else begin
                push  = 1'b1;
                ie_d  = 1'b0;
                isp_d = lvl_i[win_idx];
                ack_d = 1'b1;
                src_d = win_idx;
            end
        end else if (di_i) begin
            ie_d = 1'b0;
        end else if (ei_i) begin
            ie_d = 1'b1;
        end
    end

    // Flag and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            isp_q <= 1'b1;
            err_q <= 1'b0;
            ack_q <= 1'b0;
            brk_q <= 1'b0;
            src_q <= '0;
        end else begin
            ie_q  <= ie_d;
            isp_q <= isp_d;
            err_q <= err_d;
            ack_q <= ack_d;
            brk_q <= brk_d;
            src_q <= src_d;
        end
    end

    assign ack_o     = ack_q;
    assign ack_src_o = src_q;
    assign brk_ack_o = brk_q;
    assign ie_o      = ie_q;
    assign isp_o     = isp_q;
    assign stk_err_o = err_q;

    p_ack_needs_ie_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(ie_o))
        else $error("acknowledge without enable");

    p_high_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !$past(isp_o)) |-> !isp_o)
        else $error("low level nested into high level");

    p_ack_clears_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !ie_o)
        else $error("enable still set after acknowledge");

    p_guard_after_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !ack_o)
        else $error("acknowledge right after return");

    p_brk_clears_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_ack_o |-> !ie_o)
        else $error("enable still set after break");

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err_o |=> stk_err_o)
        else $error("error flag cleared");

    p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_o && brk_ack_o))
        else $error("break and acknowledge together");
endmodule

// File: tb/nest_irq_arbiter_tb_top.sv
module nest_irq_arbiter_tb_top;
    localparam int N  = 6;
    localparam int D  = 3;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req = '0, msk = '0, lvl = '0;
    logic ei = 0, di = 0, reti = 0, ins = 0, brk = 0;
    logic ack, brk_ack, ie, isp, err;
    logic [SW-1:0] src;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference model state
    int m_ie, m_isp, m_err, m_guard, m_sp, e_ack, e_src, e_brk;
    int s_ie [D];
    int s_isp[D];

    nest_irq_arbiter #(.NUM_SRC(N), .STACK_DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(msk), .lvl_i(lvl),
        .ei_i(ei), .di_i(di), .reti_i(reti), .insn_done_i(ins), .brk_i(brk),
        .ack_o(ack), .ack_src_o(src), .brk_ack_o(brk_ack),
        .ie_o(ie), .isp_o(isp), .stk_err_o(err)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int win;
        e_ack = 0; e_brk = 0; win = -1;
        for (int i = N - 1; i >= 0; i--)
            if (req[i] && !msk[i] && (!lvl[i] || m_isp == 1)) win = i;
        if (reti) begin
            if (m_sp == 0) m_err = 1;
            else begin m_sp--; m_ie = s_ie[m_sp]; m_isp = s_isp[m_sp]; end
        end else if (brk) begin
            if (m_sp == D) m_err = 1;
            else begin
                s_ie[m_sp] = m_ie; s_isp[m_sp] = m_isp; m_sp++;
                m_ie = 0; e_brk = 1;
            end
        end else if (!m_guard && m_ie == 1 && win >= 0) begin
            if (m_sp == D) m_err = 1;
            else begin
                s_ie[m_sp] = m_ie; s_isp[m_sp] = m_isp; m_sp++;
                m_ie = 0; m_isp = lvl[win]; e_ack = 1; e_src = win;
            end
        end else if (di) m_ie = 0;
        else if (ei) m_ie = 1;
        if (reti) m_guard = 1;
        else if (ins) m_guard = 0;
    endtask

    // One clock: model next values from the current inputs, then compare.
    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "ack", ack, e_ack);
        if (e_ack == 1) chk(tag, "src", src, e_src);
        chk(tag, "brk_ack", brk_ack, e_brk);
        chk(tag, "ie", ie, m_ie);
        chk(tag, "isp", isp, m_isp);
        chk(tag, "err", err, m_err);
    endtask

    task automatic strobes(bit e, bit d, bit r, bit n, bit b);
        ei = e; di = d; reti = r; ins = n; brk = b;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_ie = 0; m_isp = 1; m_err = 0; m_guard = 0; m_sp = 0;
        e_ack = 0; e_src = 0; e_brk = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk("R1", "ie", ie, 0);
        chk("R1", "isp", isp, 1);
        chk("R1", "err", err, 0);
        chk("R1", "ack", ack, 0);
        chk("R1", "brk_ack", brk_ack, 0);
        strobes(0, 0, 0, 0, 0); cyc("R1");

        // R10 enable strobe
        strobes(1, 0, 0, 0, 0); cyc("R10");
        chk("R10", "ie after ei", ie, 1);
        // R2/R5 take low-level source 3
        strobes(0, 0, 0, 0, 0); req = 6'b001000; lvl = 6'b001010; cyc("R2");
        chk("R2", "ack", ack, 1); chk("R2", "src", src, 3);
        chk("R5", "isp", isp, 1); chk("R5", "ie", ie, 0);
        req = '0;
        // R3 high level nests into low
        strobes(1, 0, 0, 0, 0); cyc("R10");
        strobes(0, 0, 0, 0, 0); req = 6'b100000; cyc("R3");
        chk("R3", "src", src, 5); chk("R3", "isp", isp, 0);
        req = '0;
        // R3/R6 low source 1 held while high in service
        strobes(1, 0, 0, 0, 0); cyc("R10");
        strobes(0, 0, 0, 0, 0); req = 6'b000010; cyc("R3");
        chk("R3", "low not taken", ack, 0);
        cyc("R6");
        // R4 tie among high sources 0 and 4, source 2 masked
        req = 6'b010111; msk = 6'b000100; cyc("R4");
        chk("R4", "ack", ack, 1); chk("R4", "src", src, 0);
        req = 6'b010010;
        // R9 overflow on a maskable take
        strobes(1, 0, 0, 0, 0); cyc("R10");
        strobes(0, 0, 0, 0, 0); cyc("R9");
        chk("R9", "err", err, 1); chk("R9", "no ack", ack, 0);
        chk("R9", "ie unchanged", ie, 1);
        // R7 return, guard, then take source 4
        strobes(0, 0, 1, 1, 0); cyc("R7");
        chk("R7", "ie restored", ie, 1); chk("R7", "isp restored", isp, 0);
        strobes(0, 0, 0, 0, 0); cyc("R7");
        chk("R7", "guard blocks", ack, 0);
        strobes(0, 0, 0, 1, 0); cyc("R7");
        chk("R7", "no ack on insn cycle", ack, 0);
        strobes(0, 0, 0, 0, 0); cyc("R7");
        chk("R7", "ack after insn", ack, 1); chk("R7", "src", src, 4);
        req = '0;
        // R9 break on full stack
        strobes(0, 0, 0, 0, 1); cyc("R9");
        chk("R9", "no brk on full", brk_ack, 0);
        // Unwind and underflow
        for (int k = 0; k < 4; k++) begin
            strobes(0, 0, 1, 0, 0); cyc("R9");
        end
        chk("R9", "isp after underflow", isp, 1);
        // R8 break with enable clear, stack empty
        strobes(0, 0, 0, 1, 0); cyc("R7");
        strobes(0, 0, 0, 0, 1); cyc("R8");
        chk("R8", "brk_ack", brk_ack, 1); chk("R8", "ie", ie, 0);
        // R10 precedence: di over ei, break over acknowledge
        strobes(1, 1, 0, 0, 0); cyc("R10");
        chk("R10", "di wins", ie, 0);
        strobes(1, 0, 0, 0, 0); cyc("R10");
        strobes(0, 0, 0, 0, 1); req = 6'b000001; lvl = '0; msk = '0; cyc("R10");
        chk("R10", "brk wins", brk_ack, 1); chk("R10", "ack lost", ack, 0);

        // Random phase against the model
        for (int t = 0; t < 3000; t++) begin
            int r;
            r = $urandom_range(0, 99);
            req = N'($urandom) & N'($urandom);
            msk = N'($urandom) & N'($urandom);
            lvl = N'($urandom);
            strobes(r < 20, r >= 20 && r < 25, r >= 25 && r < 33,
                    $urandom_range(0, 1) == 1, r >= 33 && r < 36);
            cyc("R6");
        end
        strobes(0, 0, 0, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule